// File: doc/BRIEF.md
# Single-Cycle Load/Store RISC Core

This block is a 32-bit processor core that completes every instruction in one clock cycle. It executes a small subset of a classic three-register RISC instruction set. The subset covers register-to-register arithmetic and logic, word loads and stores, a branch when two registers are equal, and an absolute jump. The datapath holds these parts:

- a program counter, with one adder for the sequential address and one for the branch target;
- a 32-entry by 32-bit register file;
- a sign extender and an ALU;
- a primary decoder and an ALU-function decoder;
- five 2:1 selectors, which choose the destination register, the second ALU operand, the write-back value, the branch path and the jump path.

The instruction store and the data store are word arrays inside the core. A loading port fills them, normally while reset is held. After reset is released, the core fetches from address 0 and executes one instruction on each rising edge. For observation, the core brings out the current PC and the instruction word. It also brings out the register-file write request and the data-store write request of the instruction now executing.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low, the PC is 0. At all times `instr_o` shows the instruction-store word at index PC/4.
- R2: Any instruction that is neither a taken branch nor a jump advances the PC by exactly 4 at the next rising edge.
- R3: With opcode 000000, the funct field [5:0] selects the operation: add 100000, sub 100010, and 100100, or 100101, slt 101010. For slt the result is 1 when rs is less than rt as signed numbers and 0 otherwise. The result goes to register rd [15:11]. Any other funct value writes nothing.
- R4: Opcode 100011 (load) writes register rt [20:16] with the data-store word at byte address rs + sign-extended imm[15:0]. Byte address 4*i selects word i.
- R5: Opcode 101011 (store) raises `dm_we_o`. The byte address is rs + sign-extended imm, and the data is the value of rt. The register file is not written.
- R6: Opcode 000100 (branch-if-equal) writes neither the register file nor the data store. When rs equals rt, the next PC is PC+4 + (sign-extended imm << 2). Otherwise it is PC+4.
- R7: Opcode 000010 (jump) sets the next PC to {PC[31:28], instr[25:0], 2'b00} and writes nothing.
- R8: Register 0 reads as zero. A write aimed at it leaves `rf_we_o` low and has no effect on later reads.
- R9: An opcode outside the five listed ones writes nothing and advances the PC by 4.
- R10: When `load_en` is high, a rising edge writes `load_data` into word `load_addr`. The word goes to the data store when `load_dmem` is 1 and to the instruction store when it is 0.
- R11: A register written by one instruction holds the new value for the very next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of PC and registers |
| load_en | input | 1 | Store-loading write strobe |
| load_dmem | input | 1 | 1 selects data store, 0 selects instruction store |
| load_addr | input | 32 | Word index for the loading write |
| load_data | input | 32 | Word to store |
| pc_o | output | 32 | Current program counter |
| instr_o | output | 32 | Instruction being executed |
| rf_we_o | output | 1 | Register write taking effect at the next edge |
| rf_waddr_o | output | 5 | Destination register number |
| rf_wdata_o | output | 32 | Value to be written to the register |
| dm_we_o | output | 1 | Data-store write taking effect at the next edge |
| dm_addr_o | output | 32 | Data-store byte address (ALU result) |
| dm_wdata_o | output | 32 | Data-store write value |

## Verification
The embedded properties check, on every cycle, the rules that tie one cycle's control to the next PC:

- sequential advance;
- the taken-branch target and the jump target;
- that branches write nothing;
- that stores do not write registers;
- that slt yields 0 or 1;
- that register 0 can neither be written nor read as nonzero.

Only the bench's scenarios can show that values are arithmetically right. They cover each ALU function across signed extremes, loads returning the stored words with positive and negative offsets, and forward and backward branches. They also cover back-to-back register dependencies and unknown opcodes and funct codes. The bench compares each of these with its own instruction-level model.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam logic [5:0] OPC_REG   = 6'b000000;
    localparam logic [5:0] OPC_JUMP  = 6'b000010;
    localparam logic [5:0] OPC_BEQ   = 6'b000100;
    localparam logic [5:0] OPC_LOAD  = 6'b100011;
    localparam logic [5:0] OPC_STORE = 6'b101011;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;

    typedef enum logic [1:0] {
        CLS_ADD,
        CLS_SUB,
        CLS_FUNCT
    } alu_cls_e;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_SLT
    } alu_op_e;

    typedef struct packed {
        logic     dst_is_rd;
        logic     b_is_imm;
        logic     wb_from_mem;
        logic     reg_write;
        logic     mem_write;
        logic     branch;
        logic     jump;
        alu_cls_e alu_cls;
    } ctrl_t;

endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctl,
    output alu_op_e    alu_op
);

    logic    funct_known;
    alu_op_e funct_op;

    always_comb begin
        funct_known = 1'b1;
        funct_op    = ALU_ADD;
        case (funct)
            FN_ADD:  funct_op = ALU_ADD;
            FN_SUB:  funct_op = ALU_SUB;
            FN_AND:  funct_op = ALU_AND;
            FN_OR:   funct_op = ALU_OR;
            FN_SLT:  funct_op = ALU_SLT;
            default: funct_known = 1'b0;
        endcase
    end

    always_comb begin
        ctl         = '0;
        ctl.alu_cls = CLS_ADD;
        case (opcode)
            OPC_REG: begin
                ctl.dst_is_rd = 1'b1;
                ctl.reg_write = funct_known;
                ctl.alu_cls   = CLS_FUNCT;
            end
            OPC_LOAD: begin
                ctl.b_is_imm    = 1'b1;
                ctl.wb_from_mem = 1'b1;
                ctl.reg_write   = 1'b1;
            end
            OPC_STORE: begin
                ctl.b_is_imm  = 1'b1;
                ctl.mem_write = 1'b1;
            end
            OPC_BEQ: begin
                ctl.branch  = 1'b1;
                ctl.alu_cls = CLS_SUB;
            end
            OPC_JUMP: begin
                ctl.jump = 1'b1;
            end
            default: ctl = '0;
        endcase
    end

    always_comb begin
        unique case (ctl.alu_cls)
            CLS_ADD:   alu_op = ALU_ADD;
            CLS_SUB:   alu_op = ALU_SUB;
            CLS_FUNCT: alu_op = funct_op;
            default:   alu_op = ALU_ADD;
        endcase
    end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int NREG = 32,
    parameter int W    = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2
);

    logic [W-1:0] cells [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        if (g == 0) begin : g_zero
            assign cells[g] = '0;
        end else begin : g_flop
            logic [W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (we && waddr == AW'(g)) begin
                    q <= wdata;
                end
            end
            assign cells[g] = q;
        end
    end

    assign rd1 = cells[ra1];
    assign rd2 = cells[ra2];

    AST_R0_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (ra1 == '0) |-> (rd1 == '0)); // R8

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero
);

    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = W'($signed(a) < $signed(b));
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int IMEM_WORDS = 256,
    parameter int DMEM_WORDS = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load_en,
    input  logic        load_dmem,
    input  logic [31:0] load_addr,
    input  logic [31:0] load_data,
    output logic [31:0] pc_o,
    output logic [31:0] instr_o,
    output logic        rf_we_o,
    output logic [4:0]  rf_waddr_o,
    output logic [31:0] rf_wdata_o,
    output logic        dm_we_o,
    output logic [31:0] dm_addr_o,
    output logic [31:0] dm_wdata_o
);

    localparam int IAW = $clog2(IMEM_WORDS);
    localparam int DAW = $clog2(DMEM_WORDS);

    logic [31:0] imem [IMEM_WORDS];
    logic [31:0] dmem [DMEM_WORDS];

    logic [31:0] pc_q, pc_plus4, br_tgt, pc_after_br, pc_next, jmp_tgt;
    logic [31:0] instr, imm_ext, rs_val, rt_val, alu_b, alu_y, dm_rdata, wb_val;
    logic [4:0]  waddr;
    logic        alu_zero, take_br;
    ctrl_t       ctl;
    alu_op_e     alu_op;

    // store loading and data-store writes
    always_ff @(posedge clk) begin
        if (load_en && !load_dmem) begin
            imem[load_addr[IAW-1:0]] <= load_data;
        end
    end

    always_ff @(posedge clk) begin
        if (load_en && load_dmem) begin
            dmem[load_addr[DAW-1:0]] <= load_data;
        end else if (rst_n && ctl.mem_write) begin
            dmem[alu_y[DAW+1:2]] <= rt_val;
        end
    end

    // fetch and decode
    assign instr   = imem[pc_q[IAW+1:2]];
    assign imm_ext = {{16{instr[15]}}, instr[15:0]};

    sc_ctrl u_ctrl (
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .ctl    (ctl),
        .alu_op (alu_op)
    );

    sc_regfile #(.NREG(32), .W(32)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we_o),
        .waddr (waddr),
        .wdata (wb_val),
        .ra1   (instr[25:21]),
        .ra2   (instr[20:16]),
        .rd1   (rs_val),
        .rd2   (rt_val)
    );

    // execute and write-back selectors
    assign waddr = ctl.dst_is_rd ? instr[15:11] : instr[20:16];
    assign alu_b = ctl.b_is_imm ? imm_ext : rt_val;

    sc_alu #(.W(32)) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .op   (alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    assign dm_rdata = dmem[alu_y[DAW+1:2]];
    assign wb_val   = ctl.wb_from_mem ? dm_rdata : alu_y;

    // next-PC selection
    assign pc_plus4    = pc_q + 32'd4;
    assign br_tgt      = pc_plus4 + {imm_ext[29:0], 2'b00};
    assign take_br     = ctl.branch & alu_zero;
    assign pc_after_br = take_br ? br_tgt : pc_plus4;
    assign jmp_tgt     = {pc_q[31:28], instr[25:0], 2'b00};
    assign pc_next     = ctl.jump ? jmp_tgt : pc_after_br;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_next;
        end
    end

    assign pc_o       = pc_q;
    assign instr_o    = instr;
    assign rf_we_o    = ctl.reg_write && (waddr != 5'd0);
    assign rf_waddr_o = waddr;
    assign rf_wdata_o = wb_val;
    assign dm_we_o    = ctl.mem_write;
    assign dm_addr_o  = alu_y;
    assign dm_wdata_o = rt_val;

    logic unused_bits;
    assign unused_bits = ^{instr[10:6], load_addr[31:IAW], load_addr[31:DAW]};

    AST_PC_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.branch && !ctl.jump) |=> (pc_q == $past(pc_q) + 32'd4)); // R2
    AST_BEQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.branch |-> (!rf_we_o && !dm_we_o)); // R6
    AST_BEQ_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.branch && rs_val == rt_val) |=> (pc_q == $past(pc_q) + 32'd4 + ($past(imm_ext) << 2))); // R6
    AST_J_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.jump |=> (pc_q == {$past(pc_q[31:28]), $past(instr[25:0]), 2'b00})); // R7
    AST_STORE_NOREG: assert property (@(posedge clk) disable iff (!rst_n)
        dm_we_o |-> !rf_we_o); // R5
    AST_SLT_BOOL: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_op == ALU_SLT) |-> (alu_y[31:1] == 31'd0)); // R3
    AST_R0_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (waddr == 5'd0) |-> !rf_we_o); // R8

endmodule

// File: tb/sc_core_tb_top.sv
module sc_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_en = 1'b0;
    logic        load_dmem = 1'b0;
    logic [31:0] load_addr = '0;
    logic [31:0] load_data = '0;
    logic [31:0] pc_o, instr_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
    logic        rf_we_o, dm_we_o;
    logic [4:0]  rf_waddr_o;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] prog [256];
    logic [31:0] mdm  [64];
    logic [31:0] mrf  [32];
    logic [31:0] vals [8];
    int          nprog;

    always #5 clk = ~clk;

    sc_core dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en    (load_en),
        .load_dmem  (load_dmem),
        .load_addr  (load_addr),
        .load_data  (load_data),
        .pc_o       (pc_o),
        .instr_o    (instr_o),
        .rf_we_o    (rf_we_o),
        .rf_waddr_o (rf_waddr_o),
        .rf_wdata_o (rf_wdata_o),
        .dm_we_o    (dm_we_o),
        .dm_addr_o  (dm_addr_o),
        .dm_wdata_o (dm_wdata_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (pc %h)", tag, act, exp, pc_o);
        end
    endtask

    function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                          input logic [4:0] rd, input logic [5:0] fn);
        return {6'b000000, rs, rt, rd, 5'b00000, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] enc_j(input logic [25:0] word_idx);
        return {6'b000010, word_idx};
    endfunction

    task automatic emit(input logic [31:0] w);
        prog[nprog] = w;
        nprog++;
    endtask

    task automatic load_word(input logic sel, input int idx, input logic [31:0] w);
        @(negedge clk);
        load_en   = 1'b1;
        load_dmem = sel;
        load_addr = 32'(idx);
        load_data = w;
        @(posedge clk);
        #1 load_en = 1'b0;
    endtask

    // one instruction: compare the design against the bench's model, then advance
    task automatic step(inout logic [31:0] mpc);
        logic [31:0] iw, a, b, imm, res, addr, npc;
        logic [5:0]  op, fn;
        logic [4:0]  rs, rt, rd;
        logic        we, mwe, known;
        logic [4:0]  wa;
        logic [31:0] wd;
        string       tg;
        iw  = prog[mpc[9:2]];
        op  = iw[31:26]; fn = iw[5:0];
        rs  = iw[25:21]; rt = iw[20:16]; rd = iw[15:11];
        a   = mrf[rs]; b = mrf[rt];
        imm = {{16{iw[15]}}, iw[15:0]};
        npc = mpc + 32'd4;
        we = 1'b0; mwe = 1'b0; wa = '0; wd = '0; addr = '0; res = '0;
        chk("R2 pc", pc_o, mpc);
        chk("R1,R10 instr", instr_o, iw);
        case (op)
            6'b000000: begin
                known = 1'b1;
                case (fn)
                    6'b100000: res = a + b;
                    6'b100010: res = a - b;
                    6'b100100: res = a & b;
                    6'b100101: res = a | b;
                    6'b101010: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                    default:   known = 1'b0;
                endcase
                we = known && rd != 0; wa = rd; wd = res;
                tg = (rd == 0) ? "R8" : ((rs == 0 || rt == 0) ? "R8,R3" : "R3,R11");
            end
            6'b100011: begin
                addr = a + imm; we = (rt != 0); wa = rt; wd = mdm[addr[7:2]]; tg = "R4";
            end
            6'b101011: begin
                addr = a + imm; mwe = 1'b1; tg = "R5";
            end
            6'b000100: begin
                if (a == b) npc = mpc + 32'd4 + (imm << 2);
                tg = "R6";
            end
            6'b000010: begin
                npc = {mpc[31:28], iw[25:0], 2'b00}; tg = "R7";
            end
            default: tg = "R9";
        endcase
        chk({tg, " rf_we"}, 32'(rf_we_o), 32'(we));
        if (we) begin
            chk({tg, " waddr"}, 32'(rf_waddr_o), 32'(wa));
            chk({tg, " wdata"}, rf_wdata_o, wd);
        end
        chk({tg, " dm_we"}, 32'(dm_we_o), 32'(mwe));
        if (mwe) begin
            chk({tg, " dm_addr"}, dm_addr_o, addr);
            chk({tg, " dm_wdata"}, dm_wdata_o, b);
            mdm[addr[7:2]] = b;
        end
        if (we) mrf[wa] = wd;
        mpc = npc;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R1 watchdog: actual running expected halted");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] mpc;
        logic [5:0]  fns [5];
        int          k, a_pos, halt;
        fns[0] = 6'b100000; fns[1] = 6'b100010; fns[2] = 6'b100100;
        fns[3] = 6'b100101; fns[4] = 6'b101010;
        vals[0] = 32'd16;        vals[1] = 32'hFFFF_FFFB; vals[2] = 32'd7;
        vals[3] = 32'h7FFF_FFFF; vals[4] = 32'h8000_0000; vals[5] = 32'd0;
        vals[6] = 32'd1;         vals[7] = 32'hA5A5_0F0F;
        for (int i = 0; i < 32; i++) mrf[i] = '0;
        for (int i = 0; i < 64; i++) mdm[i] = (i < 8) ? vals[i] : 32'(i * 3);
        for (int i = 0; i < 256; i++) prog[i] = '0;

        // program build
        nprog = 0;
        for (int i = 0; i < 8; i++) emit(enc_i(6'b100011, 5'd0, 5'(i + 1), 16'(4 * i)));
        k = 0;
        for (int f = 0; f < 5; f++)
            for (int x = 2; x <= 5; x++)
                for (int y = 2; y <= 5; y++) begin
                    emit(enc_r(5'(x), 5'(y), 5'(10 + (k % 20)), fns[f]));
                    k++;
                end
        emit(enc_r(5'd2, 5'd3, 5'd0, 6'b100000));     // write aimed at r0
        emit(enc_r(5'd0, 5'd3, 5'd9, 6'b100101));     // r0 read after
        emit(enc_r(5'd2, 5'd3, 5'd30, 6'b100000));    // dependency chain
        emit(enc_r(5'd30, 5'd30, 5'd31, 6'b100010));
        emit(enc_r(5'd31, 5'd2, 5'd29, 6'b101010));
        emit(enc_r(5'd2, 5'd3, 5'd14, 6'b000000));    // unknown funct
        emit(enc_i(6'b001000, 5'd2, 5'd14, 16'd5));   // unknown opcode
        emit(enc_i(6'b101011, 5'd1, 5'd4, 16'd8));    // store to word 6
        emit(enc_i(6'b100011, 5'd1, 5'd12, 16'd8));
        emit(enc_i(6'b101011, 5'd1, 5'd3, 16'hFFFC)); // store to word 3
        emit(enc_i(6'b100011, 5'd1, 5'd13, 16'hFFFC));
        emit(enc_i(6'b000100, 5'd2, 5'd3, 16'd5));    // not taken
        emit(enc_i(6'b000100, 5'd2, 5'd2, 16'd2));    // taken forward
        emit(enc_r(5'd2, 5'd2, 5'd15, 6'b100000));
        emit(enc_r(5'd3, 5'd3, 5'd15, 6'b100000));
        a_pos = nprog;
        emit(enc_i(6'b000100, 5'd0, 5'd0, 16'd2));    // forward to back-branch
        emit(enc_j(26'(a_pos + 5)));                  // jump past the block
        emit(enc_r(5'd4, 5'd4, 5'd16, 6'b100000));
        emit(enc_i(6'b000100, 5'd0, 5'd0, 16'hFFFD)); // backward branch
        emit(enc_r(5'd5, 5'd5, 5'd16, 6'b100000));
        emit(enc_r(5'd12, 5'd13, 5'd17, 6'b100000));
        halt = nprog;
        emit(enc_j(26'(halt)));

        for (int i = 0; i < nprog; i++) load_word(1'b0, i, prog[i]);
        for (int i = 0; i < 64; i++) load_word(1'b1, i, mdm[i]);

        @(negedge clk);
        chk("R1 reset pc", pc_o, 32'd0);
        chk("R1 reset rf_we", 32'(rf_we_o), 32'(prog[0][31:26] == 6'b100011));
        rst_n = 1'b1;

        mpc = 32'd0;
        while (mpc != 32'(halt * 4)) step(mpc);
        step(mpc);
        chk("R7 halt self-jump", mpc, 32'(halt * 4));
        chk("R2 final pc", pc_o, 32'(halt * 4));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule